// File: doc/BRIEF.md
# Two-Stage Base-Tick Divider

This block turns a system reference clock somewhere between 4 and 25 MHz into a regular timing strobe near 1 MHz. A single-wire bus master uses that strobe as the time base for its slots. The division happens in two stages in series. An odd-ratio prescaler divides by 1, 3, 5 or 7. A power-of-two stage then divides by 1 to 128. Together they give composite ratios such as 6, 10, 12, 14, 20 and 24 from one 5-bit code.

Software programs the block through an 8-bit configuration register with a plain write/read port. The top bit of that register is a master enable. While the enable is clear, both counters are held at zero and no strobe is produced. This is the block's low-power idle state. The output is a strobe one reference cycle wide in the reference clock domain, plus a flag that shows whether the divider is running.

Top module: `btg_top`

## Requirements
- R1: After reset the register reads 0x00, `running` is 0 and `baseTick` stays low.
- R2: A write with `cfgWe` high stores bit 7 (enable), bits 4:2 (divide code D) and bits 1:0 (prescale code P). These become visible on `cfgRdata` in the cycle after the write edge. Bits 6:5 always read 0 and writing them has no effect. Without a write, the register holds its value.
- R3: The prescaler divides the reference clock by 2*P+1, so codes 0, 1, 2 and 3 give ratios 1, 3, 5 and 7.
- R4: The second stage divides the prescaler output by 2^D. While enabled, `baseTick` is high for exactly one cycle in every (2*P+1)*2^D reference cycles.
- R5: While bit 7 is 0, `baseTick` never goes high, whatever values the code fields hold.
- R6: Every register write clears both stages. After a write at clock edge E that leaves the block enabled with total ratio N, the first tick is sampled in the N-th cycle after E, and the next tick follows N cycles later.
- R7: `running` equals the stored enable bit.
- R8: These register values must give these ratios: 0x86 gives 10, 0x8D gives 24, 0x90 gives 16, and 0x83 gives 7.
- R9: With P=0 and D=0 while enabled, `baseTick` is high in every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfgWe | input | 1 | Register write enable |
| cfgWdata | input | 8 | Register write data |
| cfgRdata | output | 8 | Register read data (bits 6:5 read 0) |
| baseTick | output | 1 | One-cycle base-time strobe |
| running | output | 1 | High while the divider is enabled |

## Verification
The bench sweeps all 32 code combinations and measures both the first tick after the write and the following interval. This catches an off-by-one in either stage, which would shift every period by a multiple of the other stage's ratio, and a power-of-two stage that decodes D wrongly. A write in the middle of a count is checked for a restart. A design that failed to clear the counters on a write would tick early. The bench also disables a running divider for longer than the largest period, so a design that only gated the output while its counters kept running, or that still counted while idle, is exposed. Writes of all ones and of only the reserved bits show whether bits 6:5 leak into the read value.

// File: rtl/btg_pkg.sv
package btg_pkg;
  localparam int CFG_W   = 8;
  localparam int PRE_W   = 2;
  localparam int DIV_W   = 3;
  localparam int EN_BIT  = 7;
  localparam int DIV_LSB = 2;
  localparam int PRE_LSB = 0;

  typedef struct packed {
    logic run;    // divider allowed to count
    logic clear;  // force both stages back to zero
  } btgStrobes_t;
endpackage

// File: rtl/btg_control.sv
module btg_control
  import btg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfgWe,
  input  logic [CFG_W-1:0] cfgWdata,
  output logic [CFG_W-1:0] cfgRdata,
  output logic [PRE_W-1:0] preCode,
  output logic [DIV_W-1:0] divCode,
  output btgStrobes_t      strobes
);
  logic             enReg;
  logic [DIV_W-1:0] divReg;
  logic [PRE_W-1:0] preReg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      enReg  <= 1'b0;
      divReg <= '0;
      preReg <= '0;
    end else if (cfgWe) begin
      enReg  <= cfgWdata[EN_BIT];
      divReg <= cfgWdata[DIV_LSB +: DIV_W];
      preReg <= cfgWdata[PRE_LSB +: PRE_W];
    end
  end

  // reserved positions between the divide field and the enable read as zero
  always_comb begin
    cfgRdata                     = '0;
    cfgRdata[EN_BIT]             = enReg;
    cfgRdata[DIV_LSB +: DIV_W]   = divReg;
    cfgRdata[PRE_LSB +: PRE_W]   = preReg;
  end

  assign preCode       = preReg;
  assign divCode       = divReg;
  assign strobes.run   = enReg;
  assign strobes.clear = cfgWe | ~enReg;

  p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
    cfgWe |=> (cfgRdata[EN_BIT] == $past(cfgWdata[EN_BIT])) &&
              (cfgRdata[DIV_LSB +: DIV_W] == $past(cfgWdata[DIV_LSB +: DIV_W])) &&
              (cfgRdata[PRE_LSB +: PRE_W] == $past(cfgWdata[PRE_LSB +: PRE_W])));

  p_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !cfgWe |=> $stable(cfgRdata));
endmodule

// File: rtl/btg_datapath.sv
module btg_datapath
  import btg_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PRE_W-1:0] preCode,
  input  logic [DIV_W-1:0] divCode,
  input  btgStrobes_t      strobes,
  output logic             baseTick
);
  localparam int PRE_CNT_W = PRE_W + 1;         // holds 2*P up to 2*(2^PRE_W-1)
  localparam int DIV_CNT_W = (1 << DIV_W) - 1;  // holds 2^D-1 up to the largest D

  logic [PRE_CNT_W-1:0] preCnt, preLast;
  logic [DIV_CNT_W-1:0] divCnt, divLast;
  logic                 preWrap, divWrap;

  assign preLast = {preCode, 1'b0};
  assign divLast = ~({DIV_CNT_W{1'b1}} << divCode);

  assign preWrap  = strobes.run && (preCnt == preLast);
  assign divWrap  = (divCnt == divLast);
  assign baseTick = preWrap && divWrap;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (strobes.clear) begin
      preCnt <= '0;
      divCnt <= '0;
    end else if (preWrap) begin
      preCnt <= '0;
      divCnt <= divWrap ? '0 : divCnt + 1'b1;
    end else begin
      preCnt <= preCnt + 1'b1;
    end
  end

  p_no_tick_idle_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.run |-> !baseTick);

  p_pre_bound_r3: assert property (@(posedge clk) disable iff (!rst_n)
    preCnt <= preLast || $past(strobes.clear));

  p_div_bound_r4: assert property (@(posedge clk) disable iff (!rst_n)
    divCnt <= divLast || $past(strobes.clear));

  p_single_tick_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (baseTick && !strobes.clear && (preLast != '0 || divLast != '0)) |=> !baseTick);

  p_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    strobes.clear |=> (preCnt == '0) && (divCnt == '0));
endmodule

// File: rtl/btg_top.sv
module btg_top
  import btg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       cfgWe,
  input  logic [7:0] cfgWdata,
  output logic [7:0] cfgRdata,
  output logic       baseTick,
  output logic       running
);
  logic [PRE_W-1:0] preCode;
  logic [DIV_W-1:0] divCode;
  btgStrobes_t      strobes;

  btg_control u_control (
    .clk      (clk),
    .rst_n    (rst_n),
    .cfgWe    (cfgWe),
    .cfgWdata (cfgWdata),
    .cfgRdata (cfgRdata),
    .preCode  (preCode),
    .divCode  (divCode),
    .strobes  (strobes)
  );

  btg_datapath u_datapath (
    .clk      (clk),
    .rst_n    (rst_n),
    .preCode  (preCode),
    .divCode  (divCode),
    .strobes  (strobes),
    .baseTick (baseTick)
  );

  assign running = strobes.run;

  p_running_r7: assert property (@(posedge clk) disable iff (!rst_n)
    running == cfgRdata[EN_BIT]);
endmodule

// File: tb/btg_top_tb.sv
module btg_top_tb;
  localparam time CLK_PERIOD = 10ns;
  localparam int  WATCHDOG_CYCLES = 150000;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       cfgWe = 1'b0;
  logic [7:0] cfgWdata = 8'h00;
  logic [7:0] cfgRdata;
  logic       baseTick;
  logic       running;

  int checks = 0;
  int failures = 0;

  btg_top u_dut (
    .clk(clk), .rst_n(rst_n), .cfgWe(cfgWe), .cfgWdata(cfgWdata),
    .cfgRdata(cfgRdata), .baseTick(baseTick), .running(running)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input bit ok, input string req, input int actual, input int expected);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  // leaves the bench at the sample point of the first cycle after the write edge
  task automatic writeCfg(input logic [7:0] value);
    @(negedge clk);
    cfgWe = 1'b1;
    cfgWdata = value;
    @(posedge clk);
    @(negedge clk);
    cfgWe = 1'b0;
  endtask

  task automatic measure(input logic [7:0] value, input int n, input string req);
    int firstAt = -1;
    int secondAt = -1;
    int count = 0;
    writeCfg(value);
    for (int k = 0; k < 2 * n; k++) begin
      if (baseTick) begin
        count++;
        if (firstAt < 0) firstAt = k;
        else if (secondAt < 0) secondAt = k;
      end
      @(negedge clk);
    end
    check(firstAt == n - 1, {req, " first tick"}, firstAt, n - 1);
    check(secondAt == 2 * n - 1, {req, " second tick"}, secondAt, 2 * n - 1);
    check(count == 2, {req, " tick count"}, count, 2);
  endtask

  task automatic t_reset();
    int ticks = 0;
    check(cfgRdata == 8'h00, "R1 reset rdata", cfgRdata, 0);
    check(running == 1'b0, "R1 reset running", running, 0);
    for (int k = 0; k < 10; k++) begin
      if (baseTick) ticks++;
      @(negedge clk);
    end
    check(ticks == 0, "R1 no tick after reset", ticks, 0);
  endtask

  task automatic t_regAccess();
    writeCfg(8'hFF);
    check(cfgRdata == 8'h9F, "R2 all-ones readback", cfgRdata, 8'h9F);
    check(running == 1'b1, "R7 running set", running, 1);
    writeCfg(8'h60);
    check(cfgRdata == 8'h00, "R2 reserved-only write", cfgRdata, 0);
    check(running == 1'b0, "R7 running clear", running, 0);
    writeCfg(8'h15);
    repeat (5) @(negedge clk);
    check(cfgRdata == 8'h15, "R2 value held", cfgRdata, 8'h15);
  endtask

  task automatic t_sweep();
    for (int d = 0; d < 8; d++) begin
      for (int p = 0; p < 4; p++) begin
        logic [7:0] v;
        v = 8'h80 | 8'(d << 2) | 8'(p);
        measure(v, (2 * p + 1) * (1 << d), "R3 R4 sweep");
      end
    end
  endtask

  task automatic t_examples();
    measure(8'h86, 10, "R8 ratio 10");
    measure(8'h8D, 24, "R8 ratio 24");
    measure(8'h90, 16, "R8 ratio 16");
    measure(8'h83, 7,  "R8 ratio 7");
  endtask

  task automatic t_ratioOne();
    int ticks = 0;
    writeCfg(8'h80);
    for (int k = 0; k < 20; k++) begin
      if (baseTick) ticks++;
      @(negedge clk);
    end
    check(ticks == 20, "R9 tick every cycle", ticks, 20);
  endtask

  task automatic t_disable();
    int ticks = 0;
    writeCfg(8'h8D);
    repeat (30) @(negedge clk);
    writeCfg(8'h0D);
    check(running == 1'b0, "R7 running after disable", running, 0);
    check(cfgRdata == 8'h0D, "R2 codes kept while idle", cfgRdata, 8'h0D);
    for (int k = 0; k < 2000; k++) begin
      if (baseTick) ticks++;
      @(negedge clk);
    end
    check(ticks == 0, "R5 no tick while disabled", ticks, 0);
    writeCfg(8'h00);
    ticks = 0;
    for (int k = 0; k < 50; k++) begin
      if (baseTick) ticks++;
      @(negedge clk);
    end
    check(ticks == 0, "R5 idle with ratio-one codes", ticks, 0);
  endtask

  task automatic t_restart();
    writeCfg(8'h90);
    repeat (9) @(negedge clk);
    measure(8'h90, 16, "R6 rewrite mid-count");
    writeCfg(8'h0F);
    repeat (7) @(negedge clk);
    measure(8'h8F, 56, "R6 enable from idle");
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_regAccess();
    t_examples();
    t_ratioOne();
    t_restart();
    t_disable();
    t_sweep();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG_CYCLES) @(posedge clk);
    checks++;
    failures++;
    $display("FAIL watchdog actual=%0d expected=%0d", WATCHDOG_CYCLES, 0);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule